// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device side of a serial NOR flash interface. A host drives a serial clock, an active-low select and a data line. The block oversamples these three inputs with its own system clock. Each transaction opens with a one-byte command code. Depending on the code, up to three address bytes, one dummy byte and any number of data bytes follow. Read-type commands stream bytes back on a serial output that changes after falling serial-clock edges. Modifying commands are held until the select line rises. Each one then either updates the local write-enable latch or issues exactly one request to the storage back-end.

Two ports face the storage. A byte-read port gives an address and expects the data one system clock later. A request port carries a program, sector erase, full erase or status write, together with its address, byte count and status byte. Program data is collected in an internal page buffer, and the back-end reads that buffer through a registered read port. While the back-end reports busy, every command except the status read is dropped without effect.

Top module: `serflash_front`

## Requirements
- R1: Command, address and data bits move most significant bit first. Input is sampled on rising serial-clock edges while select is low, and the first byte after select falls is the command code.
- R2: Code 03h, followed by 3 address bytes, returns array bytes starting at that address. Output bits change after falling edges, the first bit appears after the falling edge that ends the last address bit, and the address rises by one per byte.
- R3: Code 0Bh behaves like 03h but takes one dummy byte after the address before output starts.
- R4: The read address uses the low AW bits of the 24 received address bits and wraps from 2^AW-1 to 0.
- R5: Code 05h returns the status byte repeatedly, with bits [7:2] from the last accepted status write, bit 1 the write-enable latch and bit 0 the busy input. The status byte after reset is 00h.
- R6: Code 9Fh returns the three ID_VAL bytes, high byte first, and 00h after them.
- R7: Code 06h sets the write-enable latch and code 04h clears it.
- R8: Code 02h, with 3 address bytes and at least one data byte, issues one request of kind 0 carrying the address and the count of data bytes, capped at PAGE. Data byte j is stored at buffer index j mod PAGE.
- R9: Code D8h with 3 address bytes issues kind 1 with that address. Code C7h issues kind 2. Code 01h with one data byte issues kind 3 with that byte on req_data and loads status bits [7:2] from it.
- R10: A modifying command (02h, D8h, C7h, 01h, 06h, 04h) takes effect only if select rises after a multiple of eight clocks and after all of its required bytes. Otherwise it is discarded, and a request only ever appears while select is high.
- R11: Kinds 0 to 3 are issued only while the write-enable latch is set, and issuing one clears the latch.
- R12: While busy is high, every code except 05h is ignored: no output is enabled, no request is issued and the latch does not change. No request is issued from a commit seen while busy is high.
- R13: A read may end at any bit with no side effect. sdo_en is low from reset and falls within three system clocks after select goes high.
- R14: Any other command code is ignored, with no output and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idle low |
| cs_n | input | 1 | Active-low select from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Drive enable for sdo (low = high impedance) |
| rd_addr | output | AW | Array read address |
| rd_data | input | 8 | Array read data, one clock after rd_addr |
| busy | input | 1 | Back-end operation in progress |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 2 | 0 program, 1 sector erase, 2 full erase, 3 status write |
| req_addr | output | AW | Request address |
| req_len | output | PW+1 | Program byte count |
| req_data | output | 8 | Status write byte |
| buf_raddr | input | PW | Page buffer read index |
| buf_rdata | output | 8 | Page buffer data, one clock after buf_raddr |

## Verification
The bench builds the block with AW=10 and PAGE=16. With these values a read that starts near address 1022 crosses the top of the array within a few bytes. A program command of 19 data bytes also runs past the page size, which exercises both the count cap and the buffer index wrap. Random read addresses set the upper address bits to arbitrary values, so the bench also shows that those bits are dropped.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam logic [7:0] OPC_RD         = 8'h03;
  localparam logic [7:0] OPC_RD_FAST    = 8'h0B;
  localparam logic [7:0] OPC_STAT_RD    = 8'h05;
  localparam logic [7:0] OPC_ID_RD      = 8'h9F;
  localparam logic [7:0] OPC_PROG       = 8'h02;
  localparam logic [7:0] OPC_ERASE_SECT = 8'hD8;
  localparam logic [7:0] OPC_ERASE_ALL  = 8'hC7;
  localparam logic [7:0] OPC_WEN_SET    = 8'h06;
  localparam logic [7:0] OPC_WEN_CLR    = 8'h04;
  localparam logic [7:0] OPC_STAT_WR    = 8'h01;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_DOUT, PH_DIN, PH_HOLD, PH_IGN
  } phase_e;

  typedef enum logic [1:0] {
    RQ_PROG = 2'd0, RQ_ERASE_SECT = 2'd1, RQ_ERASE_ALL = 2'd2, RQ_STAT_WR = 2'd3
  } req_kind_e;
endpackage

// File: rtl/sff_insync.sv
module sff_insync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic rise,
  output logic fall,
  output logic sdi_q,
  output logic cs_act,
  output logic cs_end
);
  logic [SYNC:0]   sck_p;
  logic [SYNC:0]   csn_p;
  logic [SYNC-1:0] sdi_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      csn_p <= '1;
      sdi_p <= '0;
    end else begin
      sck_p <= {sck_p[SYNC-1:0], sclk};
      csn_p <= {csn_p[SYNC-1:0], cs_n};
      if (SYNC > 1) sdi_p <= {sdi_p[SYNC-2:0], sdi};
      else          sdi_p <= sdi;
    end
  end

  assign rise   = sck_p[SYNC-1] & ~sck_p[SYNC];
  assign fall   = ~sck_p[SYNC-1] & sck_p[SYNC];
  assign sdi_q  = sdi_p[SYNC-1];
  assign cs_act = ~csn_p[SYNC-1];
  assign cs_end = csn_p[SYNC-1] & ~csn_p[SYNC];
endmodule

// File: rtl/sff_pagebuf.sv
module sff_pagebuf #(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sff_dout.sv
module sff_dout (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_act,
  input  logic       fall,
  input  logic       arm,
  input  logic [7:0] nxt_byte,
  output logic       sdo,
  output logic       sdo_en,
  output logic       take
);
  logic [6:0] sh_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
      take   <= 1'b0;
    end else begin
      take <= 1'b0;
      if (fall && arm) begin
        cnt_q  <= cnt_q + 3'd1;
        sdo_en <= 1'b1;
        if (cnt_q == 3'd0) begin
          sdo  <= nxt_byte[7];
          sh_q <= nxt_byte[6:0];
          take <= 1'b1;
        end else begin
          sdo  <= sh_q[6];
          sh_q <= {sh_q[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sff_cmd.sv
module sff_cmd import sff_pkg::*; #(
  parameter int          AW     = 24,
  parameter int          PAGE   = 256,
  parameter logic [23:0] ID_VAL = 24'h3A7115,
  localparam int         PW     = $clog2(PAGE),
  localparam int         LW     = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          cs_end,
  input  logic          rise,
  input  logic          sdi_q,
  input  logic          busy,
  input  logic          take,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          arm,
  output logic [7:0]    nxt_byte,
  output logic          buf_we,
  output logic [PW-1:0] buf_waddr,
  output logic [7:0]    buf_wdata,
  output logic          req_valid,
  output logic [1:0]    req_kind,
  output logic [AW-1:0] req_addr,
  output logic [LW-1:0] req_len,
  output logic [7:0]    req_data,
  output logic          wel
);
  phase_e        phase_q;
  logic [7:0]    op_q;
  logic [6:0]    sh_q;
  logic [2:0]    bitc_q;
  logic [1:0]    acnt_q;
  logic [23:0]   addr_q;
  logic [LW-1:0] dcnt_q;
  logic [PW-1:0] wptr_q;
  logic [7:0]    data_q;
  logic [5:0]    sr_hi_q;
  logic [1:0]    id_idx_q;
  logic [AW-1:0] rd_addr_q;

  logic [7:0]  byte_in;
  logic        byte_done;
  logic [23:0] addr_nx;

  assign byte_in   = {sh_q, sdi_q};
  assign byte_done = cs_act && rise && (bitc_q == 3'd7);
  assign addr_nx   = {addr_q[15:0], byte_in};

  assign buf_we    = byte_done && (phase_q == PH_DIN) && (op_q == OPC_PROG);
  assign buf_waddr = wptr_q;
  assign buf_wdata = byte_in;
  assign arm       = (phase_q == PH_DOUT);
  assign rd_addr   = rd_addr_q;

  always_comb begin
    case (op_q)
      OPC_RD, OPC_RD_FAST: nxt_byte = rd_data;
      OPC_STAT_RD:         nxt_byte = {sr_hi_q, wel, busy};
      OPC_ID_RD: begin
        case (id_idx_q)
          2'd0:    nxt_byte = ID_VAL[23:16];
          2'd1:    nxt_byte = ID_VAL[15:8];
          2'd2:    nxt_byte = ID_VAL[7:0];
          default: nxt_byte = 8'h00;
        endcase
      end
      default: nxt_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_OPC;
      op_q      <= 8'h00;
      sh_q      <= '0;
      bitc_q    <= '0;
      acnt_q    <= '0;
      addr_q    <= '0;
      dcnt_q    <= '0;
      wptr_q    <= '0;
      data_q    <= '0;
      sr_hi_q   <= '0;
      id_idx_q  <= '0;
      rd_addr_q <= '0;
      wel       <= 1'b0;
      req_valid <= 1'b0;
      req_kind  <= '0;
      req_addr  <= '0;
      req_len   <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (!cs_act) begin
        phase_q  <= PH_OPC;
        bitc_q   <= '0;
        acnt_q   <= '0;
        dcnt_q   <= '0;
        wptr_q   <= '0;
        id_idx_q <= '0;
        // commit only on a byte boundary and only when the back-end is idle
        if (cs_end && (bitc_q == 3'd0) && !busy) begin
          case (phase_q)
            PH_HOLD: begin
              case (op_q)
                OPC_WEN_SET: wel <= 1'b1;
                OPC_WEN_CLR: wel <= 1'b0;
                OPC_ERASE_SECT, OPC_ERASE_ALL: begin
                  if (wel) begin
                    req_valid <= 1'b1;
                    req_kind  <= (op_q == OPC_ERASE_SECT) ? RQ_ERASE_SECT : RQ_ERASE_ALL;
                    req_addr  <= addr_q[AW-1:0];
                    req_len   <= '0;
                    wel       <= 1'b0;
                  end
                end
                default: ;
              endcase
            end
            PH_DIN: begin
              if (wel && (dcnt_q != '0)) begin
                req_valid <= 1'b1;
                req_addr  <= addr_q[AW-1:0];
                req_len   <= dcnt_q;
                req_data  <= data_q;
                wel       <= 1'b0;
                if (op_q == OPC_PROG) begin
                  req_kind <= RQ_PROG;
                end else begin
                  req_kind <= RQ_STAT_WR;
                  sr_hi_q  <= data_q[7:2];
                end
              end
            end
            default: ;
          endcase
        end
      end else begin
        if (rise) begin
          sh_q   <= byte_in[6:0];
          bitc_q <= bitc_q + 3'd1;
        end
        if (byte_done) begin
          case (phase_q)
            PH_OPC: begin
              op_q <= byte_in;
              if (busy && (byte_in != OPC_STAT_RD)) begin
                phase_q <= PH_IGN;
              end else begin
                case (byte_in)
                  OPC_RD, OPC_RD_FAST, OPC_PROG, OPC_ERASE_SECT: phase_q <= PH_ADDR;
                  OPC_STAT_RD, OPC_ID_RD:                        phase_q <= PH_DOUT;
                  OPC_WEN_SET, OPC_WEN_CLR, OPC_ERASE_ALL:       phase_q <= PH_HOLD;
                  OPC_STAT_WR:                                   phase_q <= PH_DIN;
                  default:                                       phase_q <= PH_IGN;
                endcase
              end
            end
            PH_ADDR: begin
              addr_q <= addr_nx;
              acnt_q <= acnt_q + 2'd1;
              if (acnt_q == 2'd2) begin
                rd_addr_q <= addr_nx[AW-1:0];
                case (op_q)
                  OPC_RD:      phase_q <= PH_DOUT;
                  OPC_RD_FAST: phase_q <= PH_DUMMY;
                  OPC_PROG:    phase_q <= PH_DIN;
                  default:     phase_q <= PH_HOLD;
                endcase
              end
            end
            PH_DUMMY: phase_q <= PH_DOUT;
            PH_DIN: begin
              if (dcnt_q != LW'(PAGE)) dcnt_q <= dcnt_q + 1'b1;
              if (dcnt_q == '0) data_q <= byte_in;
              wptr_q <= wptr_q + 1'b1;
            end
            default: ;
          endcase
        end
        if (take) begin
          if (op_q == OPC_ID_RD) begin
            if (id_idx_q != 2'd3) id_idx_q <= id_idx_q + 2'd1;
          end else begin
            rd_addr_q <= rd_addr_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serflash_front.sv
module serflash_front #(
  parameter int          AW     = 24,
  parameter int          PAGE   = 256,
  parameter int          SYNC   = 2,
  parameter logic [23:0] ID_VAL = 24'h3A7115,
  localparam int         PW     = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  input  logic          busy,
  output logic          req_valid,
  output logic [1:0]    req_kind,
  output logic [AW-1:0] req_addr,
  output logic [PW:0]   req_len,
  output logic [7:0]    req_data,
  input  logic [PW-1:0] buf_raddr,
  output logic [7:0]    buf_rdata
);
  logic          rise, fall, sdi_q, cs_act, cs_end;
  logic          take, arm, wel_w;
  logic [7:0]    nxt_byte;
  logic          buf_we;
  logic [PW-1:0] buf_waddr;
  logic [7:0]    buf_wdata;

  sff_insync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .rise(rise), .fall(fall), .sdi_q(sdi_q), .cs_act(cs_act), .cs_end(cs_end)
  );

  sff_cmd #(.AW(AW), .PAGE(PAGE), .ID_VAL(ID_VAL)) u_cmd (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_end(cs_end), .rise(rise),
    .sdi_q(sdi_q), .busy(busy), .take(take), .rd_data(rd_data),
    .rd_addr(rd_addr), .arm(arm), .nxt_byte(nxt_byte),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_len(req_len), .req_data(req_data), .wel(wel_w)
  );

  sff_dout u_dout (
    .clk(clk), .rst(rst), .cs_act(cs_act), .fall(fall), .arm(arm),
    .nxt_byte(nxt_byte), .sdo(sdo), .sdo_en(sdo_en), .take(take)
  );

  sff_pagebuf #(.DEPTH(PAGE)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );
endmodule

// File: rtl/sff_chk.sv
module sff_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sdo_en,
  input logic busy,
  input logic req_valid,
  input logic wel
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid) else $error("request longer than one cycle"); // R8

  AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !$past(busy)) else $error("request issued while busy"); // R12

  AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ($past(wel) && !wel)) else $error("request without latch"); // R11

  AST_REQ_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> cs_n) else $error("request during selected transfer"); // R10

  AST_TRISTATE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en)
    else $error("output driven while deselected"); // R13
endmodule

bind serflash_front sff_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdo_en(sdo_en), .busy(busy),
  .req_valid(req_valid), .wel(wel_w)
);

// File: tb/tb_serflash_front.sv
module tb_serflash_front;
  localparam int          AW     = 10;
  localparam int          PAGE   = 16;
  localparam int          PW     = $clog2(PAGE);
  localparam int          HALF   = 6;
  localparam logic [23:0] ID_VAL = 24'h3A7115;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, busy = 1'b0;
  logic          sdo, sdo_en, req_valid;
  logic [AW-1:0] rd_addr, req_addr;
  logic [7:0]    rd_data, req_data, buf_rdata;
  logic [1:0]    req_kind;
  logic [PW:0]   req_len;
  logic [PW-1:0] buf_raddr = '0;

  serflash_front #(.AW(AW), .PAGE(PAGE), .ID_VAL(ID_VAL)) dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .sdo_en(sdo_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_len(req_len), .req_data(req_data), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata)
  );

  function automatic logic [7:0] mem_byte(input int a);
    int v;
    v = (a % (1 << AW)) * 37 + (a % (1 << AW)) / 16;
    return 8'(v) ^ 8'h5a;
  endfunction

  always_ff @(posedge clk) rd_data <= mem_byte(int'(rd_addr));

  int            nreq = 0;
  logic [1:0]    c_kind;
  logic [AW-1:0] c_addr;
  logic [PW:0]   c_len;
  logic [7:0]    c_data;
  always @(posedge clk) begin
    if (!rst && req_valid) begin
      nreq   <= nreq + 1;
      c_kind <= req_kind;
      c_addr <= req_addr;
      c_len  <= req_len;
      c_data <= req_data;
    end
  end

  int   total = 0, bad = 0;
  logic [7:0] tx [64];
  logic [7:0] rx [64];
  logic [7:0] exp_buf [PAGE];
  bit   en_seen;
  logic [5:0] exp_sr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nbits);
    en_seen = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int t = 0; t < nbits; t++) begin
      sdi = tx[t/8][7-(t%8)];
      repeat (HALF) @(negedge clk);
      rx[t/8][7-(t%8)] = sdo;
      if (sdo_en) en_seen = 1'b1;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_op(input logic [7:0] op, input int nbits);
    tx[0] = op;
    xfer(nbits);
  endtask

  task automatic check_status(input logic wel_e, input string tag);
    logic [7:0] e;
    e = {exp_sr, wel_e, busy};
    tx[0] = 8'h05;
    xfer(24);
    chk(rx[1] == e && rx[2] == e, tag, int'(rx[1]), int'(e));
  endtask

  task automatic set_addr(input logic [23:0] a);
    tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
  endtask

  task automatic read_buf(input int i, output logic [7:0] v);
    @(negedge clk); buf_raddr = PW'(i);
    @(negedge clk); v = buf_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] a;
    logic [7:0]  v;
    int n, r0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) tx[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdo_en == 1'b0, "R13 reset sdo_en", int'(sdo_en), 0);
    chk(req_valid == 1'b0, "R8 reset req_valid", int'(req_valid), 0);
    check_status(1'b0, "R5 status after reset");

    // R6 identification
    send_op(8'h9F, 8 * 6);
    chk({rx[1], rx[2], rx[3]} == ID_VAL, "R6 id bytes", int'({rx[1], rx[2], rx[3]}), int'(ID_VAL));
    chk(rx[4] == 8'h00 && rx[5] == 8'h00, "R6 id tail", int'({rx[4], rx[5]}), 0);

    // R1 R2 random reads
    for (int k = 0; k < 4; k++) begin
      a = 24'($urandom); n = 1 + int'($urandom % 6);
      tx[0] = 8'h03; set_addr(a);
      xfer(32 + 8 * n);
      chk(en_seen, "R2 output enabled", int'(en_seen), 1);
      for (int i = 0; i < n; i++)
        chk(rx[4+i] == mem_byte(int'(a[AW-1:0]) + i), "R1 R2 read byte", int'(rx[4+i]),
            int'(mem_byte(int'(a[AW-1:0]) + i)));
    end

    // R3 fast read with dummy byte
    for (int k = 0; k < 3; k++) begin
      a = 24'($urandom); n = 1 + int'($urandom % 5);
      tx[0] = 8'h0B; set_addr(a); tx[4] = 8'($urandom);
      xfer(40 + 8 * n);
      for (int i = 0; i < n; i++)
        chk(rx[5+i] == mem_byte(int'(a[AW-1:0]) + i), "R3 fast read byte", int'(rx[5+i]),
            int'(mem_byte(int'(a[AW-1:0]) + i)));
    end

    // R4 wrap at top of array
    a = {8'hA5, 16'((1 << AW) - 2)};
    tx[0] = 8'h03; set_addr(a);
    xfer(32 + 32);
    for (int i = 0; i < 4; i++)
      chk(rx[4+i] == mem_byte(((1 << AW) - 2 + i) % (1 << AW)), "R4 wrap byte", int'(rx[4+i]),
          int'(mem_byte(((1 << AW) - 2 + i) % (1 << AW))));

    // R13 read ended mid-byte
    r0 = nreq;
    a = 24'($urandom);
    tx[0] = 8'h03; set_addr(a);
    xfer(32 + 8 + 5);
    chk(rx[4] == mem_byte(int'(a[AW-1:0])), "R13 partial read byte", int'(rx[4]), int'(mem_byte(int'(a[AW-1:0]))));
    chk(sdo_en == 1'b0, "R13 sdo_en after select high", int'(sdo_en), 0);
    chk(nreq == r0, "R13 no request after read", nreq, r0);
    check_status(1'b0, "R13 status unchanged");

    // R7 latch set and clear, R10 boundary rule
    send_op(8'h06, 8);  check_status(1'b1, "R7 latch set");
    send_op(8'h04, 8);  check_status(1'b0, "R7 latch cleared");
    send_op(8'h06, 12); check_status(1'b0, "R10 set off boundary discarded");
    send_op(8'h06, 8);
    send_op(8'h04, 7);  check_status(1'b1, "R10 clear off boundary discarded");
    send_op(8'h04, 8);

    // R11 program without latch
    r0 = nreq;
    tx[0] = 8'h02; set_addr(24'h000123); tx[4] = 8'h77;
    xfer(40);
    chk(nreq == r0, "R11 program without latch", nreq, r0);

    // R8 program random length
    send_op(8'h06, 8);
    r0 = nreq;
    a = 24'($urandom); n = 1 + int'($urandom % PAGE);
    tx[0] = 8'h02; set_addr(a);
    for (int i = 0; i < n; i++) begin tx[4+i] = 8'($urandom); exp_buf[i % PAGE] = tx[4+i]; end
    xfer(32 + 8 * n);
    chk(nreq == r0 + 1, "R8 one request", nreq, r0 + 1);
    chk(c_kind == 2'd0 && c_addr == a[AW-1:0], "R8 kind and addr", int'({c_kind, c_addr}), int'({2'd0, a[AW-1:0]}));
    chk(int'(c_len) == n, "R8 length", int'(c_len), n);
    for (int i = 0; i < n; i++) begin
      read_buf(i, v);
      chk(v == exp_buf[i], "R8 buffer byte", int'(v), int'(exp_buf[i]));
    end
    check_status(1'b0, "R11 latch cleared by program");

    // R8 overflow past page
    send_op(8'h06, 8);
    n = PAGE + 3;
    tx[0] = 8'h02; set_addr(24'h000040);
    for (int i = 0; i < n; i++) begin tx[4+i] = 8'($urandom); exp_buf[i % PAGE] = tx[4+i]; end
    xfer(32 + 8 * n);
    chk(int'(c_len) == PAGE, "R8 length capped", int'(c_len), PAGE);
    for (int i = 0; i < 4; i++) begin
      read_buf(i, v);
      chk(v == exp_buf[i], "R8 wrapped buffer byte", int'(v), int'(exp_buf[i]));
    end

    // R9 sector erase, R10 broken erase, full erase, status write
    send_op(8'h06, 8);
    r0 = nreq; a = 24'($urandom);
    tx[0] = 8'hD8; set_addr(a);
    xfer(32);
    chk(nreq == r0 + 1 && c_kind == 2'd1 && c_addr == a[AW-1:0], "R9 sector erase", int'({c_kind, c_addr}),
        int'({2'd1, a[AW-1:0]}));
    send_op(8'h06, 8);
    r0 = nreq;
    tx[0] = 8'hD8; set_addr(a);
    xfer(33);
    chk(nreq == r0, "R10 erase off boundary", nreq, r0);
    tx[0] = 8'hD8; xfer(24);
    chk(nreq == r0, "R10 erase missing address", nreq, r0);
    send_op(8'hC7, 8);
    chk(nreq == r0 + 1 && c_kind == 2'd2, "R9 full erase", int'(c_kind), 2);
    send_op(8'h06, 8);
    tx[0] = 8'h01; tx[1] = 8'hA4;
    xfer(16);
    chk(c_kind == 2'd3 && c_data == 8'hA4, "R9 status write", int'({c_kind, c_data}), int'({2'd3, 8'hA4}));
    exp_sr = 6'(8'hA4 >> 2);
    check_status(1'b0, "R9 status bits loaded");

    // R12 busy gating
    send_op(8'h06, 8);
    busy = 1'b1;
    check_status(1'b1, "R12 status read while busy");
    tx[0] = 8'h03; set_addr(24'h000010);
    xfer(48);
    chk(!en_seen, "R12 read ignored while busy", int'(en_seen), 0);
    r0 = nreq;
    tx[0] = 8'hD8; set_addr(24'h000200);
    xfer(32);
    chk(nreq == r0, "R12 erase ignored while busy", nreq, r0);
    send_op(8'h04, 8);
    check_status(1'b1, "R12 clear ignored while busy");
    busy = 1'b0;
    check_status(1'b1, "R12 latch kept after busy");

    // R14 unknown code
    r0 = nreq;
    tx[0] = 8'h5C; tx[1] = 8'h12;
    xfer(24);
    chk(!en_seen && nreq == r0, "R14 unknown code ignored", int'(en_seen), 0);
    check_status(1'b1, "R14 latch untouched");
    send_op(8'h04, 8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule